// File: doc/BRIEF.md
# Indirect Pointer/Counter DMA Channel

This block is one DMA channel that moves a single byte each time its peripheral asks for service. The channel keeps no address or length state of its own between transfers. On every accepted request it fetches a byte counter and an address pointer from a shared register file, at a base location that the peripheral presents. It then moves one byte between the peripheral data path and the selected storage, and writes the advanced pointer and the reduced counter back to the same register-file locations.

Two storage targets are supported. The first is the register file itself, which uses an 8-bit counter and an 8-bit pointer, one register each. The second is a byte-wide memory, which uses a 16-bit counter and a 16-bit pointer, each held as a register pair. A direction input chooses whether the byte goes from the peripheral into storage or from storage out to the peripheral. When the last byte of a block has moved, the channel pulses `done` and stays quiet until software re-arms it.

Top module: `dma_pc_channel`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `gnt`, `done`, `rf_we` and `mem_we` are all low.
- R2: With `dst_mem`=0, the counter is read from register-file address `base_addr` and the pointer from `base_addr`+1. One transfer writes back counter-1 and pointer+1, both 8-bit. `gnt` rises on the 6th rising clock edge after `req` is first seen high.
- R3: With `dst_mem`=1, `base_addr` must be even. The counter high byte is at `base_addr`, its low byte at `base_addr`+1, the pointer high byte at `base_addr`+2 and its low byte at `base_addr`+3. Both are updated as 16-bit values, with carry and borrow crossing the byte boundary. `gnt` rises on the 10th rising edge after `req` is seen.
- R4: With `dir`=0, `periph_wdata` is written to storage at the fetched pointer. With `dir`=1, the storage byte at the fetched pointer is presented on `periph_rdata` while `gnt` is high.
- R5: Data moves use the memory port only when `dst_mem`=1 and the register-file port only when `dst_mem`=0. The two write enables are never high in the same cycle.
- R6: `gnt` is high for exactly one cycle per accepted request.
- R7: `done` is high together with `gnt`, for that one cycle only, exactly when the written-back counter is zero.
- R8: After `done`, requests get no `gnt` and cause no writes until a one-cycle `arm` pulse is given.
- R9: A 16-bit memory counter read as 0 stands for 65536 bytes. The transfer proceeds, writes back 0xFFFF and does not raise `done`.
- R10: A register-file counter read as 0 makes the channel drop the request. No `gnt` is given and nothing is written.
- R11: Pointers wrap at their width: an 8-bit pointer goes from 0xFF to 0x00, and a 16-bit pointer goes from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Peripheral service request, held until `gnt` |
| arm | input | 1 | One-cycle pulse that re-enables the channel after `done` |
| base_addr | input | DW | Register-file location of the counter/pointer block |
| dst_mem | input | 1 | 1: memory target, 0: register-file target |
| dir | input | 1 | 0: peripheral to storage, 1: storage to peripheral |
| periph_wdata | input | DW | Byte offered by the peripheral |
| periph_rdata | output | DW | Byte fetched for the peripheral, valid with `gnt` |
| gnt | output | 1 | One-cycle service acknowledge |
| done | output | 1 | One-cycle end-of-block flag |
| rf_addr | output | DW | Register-file address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | DW | Register-file write data |
| rf_rdata | input | DW | Register-file read data, combinational from `rf_addr` |
| mem_addr | output | 2*DW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, combinational from `mem_addr` |

## Verification
The bench targets pointer values whose increment must carry from the low byte into the high byte, or wrap all the way to zero. A design that updated each byte on its own would leave 0x00FF at 0x0000, or would corrupt the high byte at 0xFFFF. It also loads a memory counter of zero: a design that treated zero as empty would refuse the transfer or raise `done` early, when it should write back 0xFFFF. After `done`, it re-arms only after trying a freshly reloaded counter, so a channel that restarted without `arm` would grant and write. Random mixes of direction and target check that data goes through the correct port and that the register-file layout offsets do not get swapped.

// File: rtl/dma_pc_pkg.sv
package dma_pc_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_CH,
      S_RD_CL,
      S_RD_PH,
      S_RD_PL,
      S_MOVE,
      S_WR_CH,
      S_WR_CL,
      S_WR_PH,
      S_WR_PL,
      S_FIN
   } dma_st_e;
endpackage

// File: rtl/dma_pc_seq.sv
module dma_pc_seq
   import dma_pc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req,
   input  logic    arm,
   input  logic    dst_mem,
   input  logic    mem_q,
   input  logic    rf_cnt_zero,
   input  logic    last,
   output dma_st_e st,
   output logic    start,
   output logic    gnt,
   output logic    done,
   output logic    halted
);
   dma_st_e st_nxt;

   assign start = (st == S_IDLE) && req && !halted;
   assign gnt   = (st == S_FIN);
   assign done  = gnt && last;

   always_comb begin
      st_nxt = st;
      case (st)
         S_IDLE:  if (start) st_nxt = dst_mem ? S_RD_CH : S_RD_CL;
         S_RD_CH: st_nxt = S_RD_CL;
         S_RD_CL: begin
            if (!mem_q && rf_cnt_zero) st_nxt = S_IDLE;
            else if (mem_q)            st_nxt = S_RD_PH;
            else                       st_nxt = S_RD_PL;
         end
         S_RD_PH: st_nxt = S_RD_PL;
         S_RD_PL: st_nxt = S_MOVE;
         S_MOVE:  st_nxt = mem_q ? S_WR_CH : S_WR_CL;
         S_WR_CH: st_nxt = S_WR_CL;
         S_WR_CL: st_nxt = mem_q ? S_WR_PH : S_WR_PL;
         S_WR_PH: st_nxt = S_WR_PL;
         S_WR_PL: st_nxt = S_FIN;
         S_FIN:   st_nxt = S_IDLE;
         default: st_nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         halted <= 1'b0;
      end else begin
         st <= st_nxt;
         if (done)     halted <= 1'b1;
         else if (arm) halted <= 1'b0;
      end
   end

   // R6
   gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |=> !gnt);

   // R8
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (st == S_IDLE));
endmodule

// File: rtl/dma_pc_dp.sv
module dma_pc_dp
   import dma_pc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  dma_st_e         st,
   input  logic            dst_mem,
   input  logic            dir,
   input  logic [DW-1:0]   base_addr,
   input  logic [DW-1:0]   periph_wdata,
   input  logic [DW-1:0]   rf_rdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            mem_q,
   output logic            last,
   output logic [DW-1:0]   rf_addr,
   output logic            rf_we,
   output logic [DW-1:0]   rf_wdata,
   output logic [2*DW-1:0] mem_addr,
   output logic            mem_we,
   output logic [DW-1:0]   mem_wdata,
   output logic [DW-1:0]   periph_rdata
);
   localparam int PW = 2 * DW;

   logic [DW-1:0] base_q;
   logic          dir_q;
   logic [DW-1:0] data_q;
   logic [PW-1:0] cnt_q, ptr_q, cnt_nxt, ptr_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         dir_q  <= 1'b0;
         mem_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (start) begin
            base_q <= base_addr;
            dir_q  <= dir;
            mem_q  <= dst_mem;
         end
         if (st == S_MOVE && dir_q)
            data_q <= mem_q ? mem_rdata : rf_rdata;
      end
   end

   // byte lanes of the fetched counter and pointer: lane 1 is the high byte
   for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      localparam dma_st_e C_ST = (ln == 1) ? S_RD_CH : S_RD_CL;
      localparam dma_st_e P_ST = (ln == 1) ? S_RD_PH : S_RD_PL;
      logic [DW-1:0] c_r, p_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_r <= '0;
            p_r <= '0;
         end else if (start) begin
            c_r <= '0;
            p_r <= '0;
         end else begin
            if (st == C_ST) c_r <= rf_rdata;
            if (st == P_ST) p_r <= rf_rdata;
         end
      end
      assign cnt_q[ln*DW +: DW] = c_r;
      assign ptr_q[ln*DW +: DW] = p_r;
   end

   always_comb begin
      if (mem_q) begin
         cnt_nxt = cnt_q - PW'(1);
         ptr_nxt = ptr_q + PW'(1);
      end else begin
         cnt_nxt = {{DW{1'b0}}, cnt_q[DW-1:0] - DW'(1)};
         ptr_nxt = {{DW{1'b0}}, ptr_q[DW-1:0] + DW'(1)};
      end
   end

   assign last = (cnt_q == PW'(1));

   always_comb begin
      rf_addr  = base_q;
      rf_we    = 1'b0;
      rf_wdata = cnt_nxt[DW-1:0];
      case (st)
         S_RD_CH: rf_addr = base_q;
         S_RD_CL: rf_addr = mem_q ? base_q + DW'(1) : base_q;
         S_RD_PH: rf_addr = base_q + DW'(2);
         S_RD_PL: rf_addr = mem_q ? base_q + DW'(3) : base_q + DW'(1);
         S_MOVE: begin
            rf_addr  = ptr_q[DW-1:0];
            rf_we    = !mem_q && !dir_q;
            rf_wdata = periph_wdata;
         end
         S_WR_CH: begin
            rf_addr  = base_q;
            rf_we    = 1'b1;
            rf_wdata = cnt_nxt[PW-1:DW];
         end
         S_WR_CL: begin
            rf_addr  = mem_q ? base_q + DW'(1) : base_q;
            rf_we    = 1'b1;
            rf_wdata = cnt_nxt[DW-1:0];
         end
         S_WR_PH: begin
            rf_addr  = base_q + DW'(2);
            rf_we    = 1'b1;
            rf_wdata = ptr_nxt[PW-1:DW];
         end
         S_WR_PL: begin
            rf_addr  = mem_q ? base_q + DW'(3) : base_q + DW'(1);
            rf_we    = 1'b1;
            rf_wdata = ptr_nxt[DW-1:0];
         end
         default: ;
      endcase
   end

   assign mem_addr     = ptr_q;
   assign mem_we       = (st == S_MOVE) && mem_q && !dir_q;
   assign mem_wdata    = periph_wdata;
   assign periph_rdata = data_q;

   // R3
   mem_base_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && dst_mem) |-> !base_addr[0]);

   // R2
   rf_ptr_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_q && st != S_IDLE) |-> (ptr_q[PW-1:DW] == '0));
endmodule

// File: rtl/dma_pc_channel.sv
module dma_pc_channel
   import dma_pc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            arm,
   input  logic [DW-1:0]   base_addr,
   input  logic            dst_mem,
   input  logic            dir,
   input  logic [DW-1:0]   periph_wdata,
   output logic [DW-1:0]   periph_rdata,
   output logic            gnt,
   output logic            done,
   output logic [DW-1:0]   rf_addr,
   output logic            rf_we,
   output logic [DW-1:0]   rf_wdata,
   input  logic [DW-1:0]   rf_rdata,
   output logic [2*DW-1:0] mem_addr,
   output logic            mem_we,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata
);
   if (DW < 4) begin : g_bad_dw
      $error("dma_pc_channel: DW must be at least 4");
   end

   dma_st_e st;
   logic    start, mem_q, last, halted;

   dma_pc_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (req),
      .arm         (arm),
      .dst_mem     (dst_mem),
      .mem_q       (mem_q),
      .rf_cnt_zero (rf_rdata == '0),
      .last        (last),
      .st          (st),
      .start       (start),
      .gnt         (gnt),
      .done        (done),
      .halted      (halted)
   );

   dma_pc_dp #(.DW(DW)) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .st           (st),
      .dst_mem      (dst_mem),
      .dir          (dir),
      .base_addr    (base_addr),
      .periph_wdata (periph_wdata),
      .rf_rdata     (rf_rdata),
      .mem_rdata    (mem_rdata),
      .mem_q        (mem_q),
      .last         (last),
      .rf_addr      (rf_addr),
      .rf_we        (rf_we),
      .rf_wdata     (rf_wdata),
      .mem_addr     (mem_addr),
      .mem_we       (mem_we),
      .mem_wdata    (mem_wdata),
      .periph_rdata (periph_rdata)
   );

   // R5
   one_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_we && mem_we));

   // R7
   done_with_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> gnt);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/dma_pc_channel_tb.sv
module dma_pc_channel_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, req, arm, dst_mem, dir;
   logic [7:0]  base_addr, periph_wdata, periph_rdata;
   logic        gnt, done, rf_we, mem_we;
   logic [7:0]  rf_addr, rf_wdata, rf_rdata, mem_wdata, mem_rdata;
   logic [15:0] mem_addr;

   logic [7:0] rf_m  [256];
   logic [7:0] mem_m [1024];
   int n_rf_wr, n_mem_wr;
   int n_chk = 0, n_fail = 0;

   assign rf_rdata  = rf_m[rf_addr];
   assign mem_rdata = mem_m[mem_addr[9:0]];

   always @(posedge clk) begin
      if (rf_we) begin
         rf_m[rf_addr] <= rf_wdata;
         n_rf_wr <= n_rf_wr + 1;
      end
      if (mem_we) begin
         mem_m[mem_addr[9:0]] <= mem_wdata;
         n_mem_wr <= n_mem_wr + 1;
      end
   end

   dma_pc_channel #(.DW(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .arm(arm), .base_addr(base_addr),
      .dst_mem(dst_mem), .dir(dir), .periph_wdata(periph_wdata),
      .periph_rdata(periph_rdata), .gnt(gnt), .done(done),
      .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string r, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rd_cnt(bit m, logic [7:0] b);
      return m ? {rf_m[b], rf_m[b + 8'd1]} : {8'h00, rf_m[b]};
   endfunction

   function automatic logic [15:0] rd_ptr(bit m, logic [7:0] b);
      return m ? {rf_m[b + 8'd2], rf_m[b + 8'd3]} : {8'h00, rf_m[b + 8'd1]};
   endfunction

   function automatic logic [15:0] f_cnt(bit m, logic [15:0] c);
      return m ? c - 16'd1 : {8'h00, c[7:0] - 8'd1};
   endfunction

   function automatic logic [15:0] f_ptr(bit m, logic [15:0] p);
      return m ? p + 16'd1 : {8'h00, p[7:0] + 8'd1};
   endfunction

   task automatic load_ch(bit m, logic [7:0] b, logic [15:0] c, logic [15:0] p);
      if (m) begin
         rf_m[b]        = c[15:8];
         rf_m[b + 8'd1] = c[7:0];
         rf_m[b + 8'd2] = p[15:8];
         rf_m[b + 8'd3] = p[7:0];
      end else begin
         rf_m[b]        = c[7:0];
         rf_m[b + 8'd1] = p[7:0];
      end
   endtask

   task automatic xfer(bit m, bit d, logic [7:0] b, string r);
      logic [15:0] c0, p0, c1, p1;
      logic [7:0]  wd, sd;
      int lat;
      bit seen;
      int exp_lat, exp_rf, exp_mem;
      c0 = rd_cnt(m, b);
      p0 = rd_ptr(m, b);
      c1 = f_cnt(m, c0);
      p1 = f_ptr(m, p0);
      wd = 8'($urandom);
      sd = m ? mem_m[p0[9:0]] : rf_m[p0[7:0]];
      exp_lat = m ? 10 : 6;
      exp_rf  = (m ? 4 : 2) + ((!m && !d) ? 1 : 0);
      exp_mem = (m && !d) ? 1 : 0;
      @(negedge clk);
      dst_mem = m; dir = d; base_addr = b; periph_wdata = wd;
      n_rf_wr = 0; n_mem_wr = 0;
      req = 1'b1;
      lat = 0; seen = 1'b0;
      while (!seen && lat < 40) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (gnt) seen = 1'b1;
      end
      chk(seen, r, "grant given", seen, 1);
      chk(lat == exp_lat, r, "grant latency", lat, exp_lat);
      // R7 done accompanies grant exactly when count reaches zero
      chk(done == (c1 == 16'd0), "R7", "done with grant", done, (c1 == 16'd0));
      // R4 read direction data
      if (d) chk(periph_rdata == sd, "R4", "read byte", periph_rdata, sd);
      req = 1'b0;
      @(negedge clk);
      chk(!gnt, "R6", "grant single cycle", gnt, 0);
      chk(!done, "R7", "done single cycle", done, 0);
      chk(rd_cnt(m, b) == c1, r, "counter writeback", rd_cnt(m, b), c1);
      chk(rd_ptr(m, b) == p1, r, "pointer writeback", rd_ptr(m, b), p1);
      if (!d) begin
         if (m) chk(mem_m[p0[9:0]] == wd, "R4", "mem byte written", mem_m[p0[9:0]], wd);
         else   chk(rf_m[p0[7:0]] == wd, "R4", "rf byte written", rf_m[p0[7:0]], wd);
      end
      // R5 port usage
      chk(n_rf_wr == exp_rf, "R5", "rf write count", n_rf_wr, exp_rf);
      chk(n_mem_wr == exp_mem, "R5", "mem write count", n_mem_wr, exp_mem);
   endtask

   task automatic expect_ignored(bit m, bit d, logic [7:0] b, string r);
      logic [15:0] c0, p0;
      bit saw;
      c0 = rd_cnt(m, b);
      p0 = rd_ptr(m, b);
      @(negedge clk);
      dst_mem = m; dir = d; base_addr = b; periph_wdata = 8'($urandom);
      n_rf_wr = 0; n_mem_wr = 0;
      req = 1'b1;
      saw = 1'b0;
      repeat (30) begin
         @(negedge clk);
         if (gnt) saw = 1'b1;
      end
      req = 1'b0;
      @(negedge clk);
      chk(!saw, r, "no grant", saw, 0);
      chk(n_rf_wr + n_mem_wr == 0, r, "no writes", n_rf_wr + n_mem_wr, 0);
      chk(rd_cnt(m, b) == c0, r, "counter untouched", rd_cnt(m, b), c0);
      chk(rd_ptr(m, b) == p0, r, "pointer untouched", rd_ptr(m, b), p0);
   endtask

   task automatic pulse_arm();
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 100000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h0D3A_5EED));
      for (int i = 0; i < 256; i++) rf_m[i] = 8'h00;
      for (int i = 0; i < 1024; i++) mem_m[i] = 8'(i * 7 + 3);
      rst_n = 1'b0; req = 1'b0; arm = 1'b0; dst_mem = 1'b0; dir = 1'b0;
      base_addr = 8'h00; periph_wdata = 8'h00;
      n_rf_wr = 0; n_mem_wr = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!gnt && !done, "R1", "gnt/done in reset", {gnt, done}, 0);
      chk(!rf_we && !mem_we, "R1", "write enables in reset", {rf_we, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!gnt && !done && !rf_we && !mem_we, "R1", "outputs after reset",
          {gnt, done, rf_we, mem_we}, 0);

      // R2 register-file target, both directions
      load_ch(1'b0, 8'h10, 16'd5, 16'h0080);
      xfer(1'b0, 1'b0, 8'h10, "R2");
      rf_m[8'hA0] = 8'h5C;
      load_ch(1'b0, 8'h12, 16'd9, 16'h00A0);
      xfer(1'b0, 1'b1, 8'h12, "R2");

      // R3 memory target, low-byte carry into the high byte
      load_ch(1'b1, 8'h20, 16'h0003, 16'h00FF);
      xfer(1'b1, 1'b0, 8'h20, "R3");
      load_ch(1'b1, 8'h24, 16'h0100, 16'h0123);
      xfer(1'b1, 1'b1, 8'h24, "R3");

      // R11 pointer wrap at both widths
      load_ch(1'b0, 8'h14, 16'd7, 16'h00FF);
      xfer(1'b0, 1'b0, 8'h14, "R11");
      load_ch(1'b1, 8'h28, 16'd7, 16'hFFFF);
      xfer(1'b1, 1'b1, 8'h28, "R11");

      // R9 memory count zero means 65536
      load_ch(1'b1, 8'h2C, 16'h0000, 16'h0200);
      xfer(1'b1, 1'b0, 8'h2C, "R9");

      // R10 register-file count zero is dropped
      load_ch(1'b0, 8'h16, 16'd0, 16'h0090);
      expect_ignored(1'b0, 1'b0, 8'h16, "R10");

      // R7 last byte raises done; R8 channel then stays quiet until armed
      load_ch(1'b0, 8'h30, 16'd1, 16'h0090);
      xfer(1'b0, 1'b0, 8'h30, "R7");
      load_ch(1'b0, 8'h30, 16'd4, 16'h0090);
      expect_ignored(1'b0, 1'b0, 8'h30, "R8");
      pulse_arm();
      xfer(1'b0, 1'b1, 8'h30, "R8");

      load_ch(1'b1, 8'h34, 16'd1, 16'h0310);
      xfer(1'b1, 1'b0, 8'h34, "R7");
      load_ch(1'b1, 8'h34, 16'd9, 16'h0310);
      expect_ignored(1'b1, 1'b1, 8'h34, "R8");
      pulse_arm();
      xfer(1'b1, 1'b0, 8'h34, "R8");

      // random mix of targets and directions
      for (int it = 0; it < 40; it++) begin
         bit m, d;
         logic [7:0]  b;
         logic [15:0] c, p;
         m = 1'($urandom_range(0, 1));
         d = 1'($urandom_range(0, 1));
         b = m ? 8'($urandom_range(0, 15) * 4) : 8'($urandom_range(0, 31) * 2);
         c = m ? 16'($urandom_range(2, 60000)) : 16'($urandom_range(2, 222));
         p = m ? 16'($urandom) : 16'($urandom_range(128, 255));
         if (m) mem_m[p[9:0]] = 8'($urandom);
         else   rf_m[p[7:0]]  = 8'($urandom);
         load_ch(m, b, c, p);
         xfer(m, d, b, m ? "R3" : "R2");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule